// File: doc/BRIEF.md
# Per-Bank Write-Engine Status Register

This block keeps one 8-bit status byte for each bank of a dual-bank flash array and returns one of them to the host on a read cycle. The write engine drives single-cycle event pulses per bank: it went busy, it finished, a program or an erase was suspended, or one of four error causes was found. The command decoder drives a clear request together with the bank it targets. Error flags are sticky. Hardware can only set them, and only the clear request removes them.

On the read side, chip-enable and output-enable (both active low) are sampled in the system clock. The register is copied into a 16-bit read word on the first clock edge at which both strobes are seen low, which is the later of the two falling edges. The copy is taken from the bank picked by the bank-select input. The word then stays frozen while both strobes stay low, so a host that polls sees stable data. The upper byte and bit 0 always read 0. When either strobe is high the read word is 0.

Top module: `flash_bank_status`

## Requirements
- R1: After reset every bank's byte is 80h: ready (bit 7) is 1 and all other bits are 0.
- R2: A busy pulse clears ready (bit 7), program-suspended (bit 2) and erase-suspended (bit 6). A done pulse sets ready. If both arrive in one cycle, done wins.
- R3: A program-suspend pulse sets bits 2 and 7. An erase-suspend pulse sets bits 6 and 7. Both take effect on the next clock edge.
- R4: The error pulses set lock error (bit 1), supply error (bit 3), program error (bit 4) and erase error (bit 5). Once set, each stays set through any busy, done or suspend pulse.
- R5: A clear request clears bits 1, 3, 4 and 5 of the addressed bank only. Bits 7, 6 and 2 of that bank are unchanged, and the other bank is unchanged.
- R6: If an error pulse and a clear request reach the same bank in the same cycle, the error bit ends up set.
- R7: Read bits 15:8 and bit 0 are always 0.
- R8: The read word is loaded on the first clock edge at which both strobes are sampled low, whichever fell later. It carries the byte as it stood just before that edge.
- R9: While both strobes stay low, the read word does not change, even if the register changes.
- R10: The bank-select value sampled at the capture edge picks which bank's byte is returned (0 or 1).
- R11: One cycle after either strobe is sampled high, the read word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_busy | input | NUM_BANKS | Write engine started, per bank |
| ev_done | input | NUM_BANKS | Write engine idle, per bank |
| ev_psus | input | NUM_BANKS | Program suspended, per bank |
| ev_esus | input | NUM_BANKS | Erase suspended, per bank |
| ev_lock_err | input | NUM_BANKS | Block-lock error, per bank |
| ev_vpp_err | input | NUM_BANKS | Supply-voltage error, per bank |
| ev_prog_err | input | NUM_BANKS | Program error, per bank |
| ev_erase_err | input | NUM_BANKS | Erase error, per bank |
| clr_req | input | 1 | Clear-status request |
| clr_bank | input | BANK_W | Bank targeted by the clear |
| rd_bank | input | BANK_W | Bank selected by the read address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | 16 | Captured read word |

## Verification
A wrong flag inside a bank stays hidden until the next capture edge. It then shows as a wrong bit in the read word one clock after both strobes are low. A lost sticky error or a clear that leaks into the other bank therefore surfaces at the next poll of the affected bank. Capture-timing faults show up at once: a word that moves while the strobes are held, or a value taken at the wrong strobe edge.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    typedef struct packed {
        logic ready;
        logic esus;
        logic erase_err;
        logic prog_err;
        logic vpp_err;
        logic psus;
        logic lock_err;
    } bank_stat_t;

    localparam int STAT_W = 8;

    // Bit positions are decoded by host software: 7 ready ... 0 reserved.
    function automatic logic [STAT_W-1:0] stat_to_byte(input bank_stat_t s);
        return {s.ready, s.esus, s.erase_err, s.prog_err,
                s.vpp_err, s.psus, s.lock_err, 1'b0};
    endfunction

endpackage

// File: rtl/flash_status_bank.sv
module flash_status_bank
    import flash_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_busy,
    input  logic              ev_done,
    input  logic              ev_psus,
    input  logic              ev_esus,
    input  logic              ev_lock_err,
    input  logic              ev_vpp_err,
    input  logic              ev_prog_err,
    input  logic              ev_erase_err,
    input  logic              clr,
    output logic [STAT_W-1:0] stat_byte
);

    bank_stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (ev_busy) begin
            stat_d.ready = 1'b0;
            stat_d.psus  = 1'b0;
            stat_d.esus  = 1'b0;
        end
        if (ev_done) stat_d.ready = 1'b1;
        if (ev_psus) begin
            stat_d.psus  = 1'b1;
            stat_d.ready = 1'b1;
        end
        if (ev_esus) begin
            stat_d.esus  = 1'b1;
            stat_d.ready = 1'b1;
        end
        if (clr) begin
            stat_d.lock_err  = 1'b0;
            stat_d.vpp_err   = 1'b0;
            stat_d.prog_err  = 1'b0;
            stat_d.erase_err = 1'b0;
        end
        // error sets placed last so they beat a simultaneous clear
        if (ev_lock_err)  stat_d.lock_err  = 1'b1;
        if (ev_vpp_err)   stat_d.vpp_err   = 1'b1;
        if (ev_prog_err)  stat_d.prog_err  = 1'b1;
        if (ev_erase_err) stat_d.erase_err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q       <= '0;
            stat_q.ready <= 1'b1;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_byte = stat_to_byte(stat_q);

    AST_SUSP_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q.psus || stat_q.esus) |-> stat_q.ready); // R3
    AST_PROG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q.prog_err && !clr) |=> stat_q.prog_err); // R4
    AST_LOCK_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q.lock_err && !clr) |=> stat_q.lock_err); // R4
    AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev_lock_err && !ev_vpp_err && !ev_prog_err && !ev_erase_err)
        |=> (!stat_q.lock_err && !stat_q.vpp_err && !stat_q.prog_err && !stat_q.erase_err)); // R5
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ev_erase_err) |=> stat_q.erase_err); // R6

endmodule

// File: rtl/flash_status_read.sv
module flash_status_read
    import flash_status_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int WORD_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [STAT_W-1:0] bank_bytes [NUM_BANKS],
    output logic [WORD_W-1:0] rd_data
);

    typedef struct packed {
        logic              on;
        logic [WORD_W-1:0] word;
    } rd_state_t;

    rd_state_t rd_d, rd_q;
    logic      strobe_on;
    logic [STAT_W-1:0] sel_byte;

    assign strobe_on = !ce_n && !oe_n;

    always_comb begin
        sel_byte = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_bank == BANK_W'(b)) sel_byte = bank_bytes[b];
        end
    end

    always_comb begin
        rd_d    = rd_q;
        rd_d.on = strobe_on;
        if (!strobe_on) begin
            rd_d.word = '0;
        end else if (!rd_q.on) begin
            rd_d.word = {{(WORD_W-STAT_W){1'b0}}, sel_byte};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.word;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[WORD_W-1:STAT_W] == '0) && !rd_data[0]); // R7
    AST_HOLD_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on && rd_q.on) |=> $stable(rd_data)); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_on |=> (rd_data == '0)); // R11

endmodule

// File: rtl/flash_bank_status.sv
module flash_bank_status
    import flash_status_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int WORD_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] ev_busy,
    input  logic [NUM_BANKS-1:0] ev_done,
    input  logic [NUM_BANKS-1:0] ev_psus,
    input  logic [NUM_BANKS-1:0] ev_esus,
    input  logic [NUM_BANKS-1:0] ev_lock_err,
    input  logic [NUM_BANKS-1:0] ev_vpp_err,
    input  logic [NUM_BANKS-1:0] ev_prog_err,
    input  logic [NUM_BANKS-1:0] ev_erase_err,
    input  logic                 clr_req,
    input  logic [BANK_W-1:0]    clr_bank,
    input  logic [BANK_W-1:0]    rd_bank,
    input  logic                 ce_n,
    input  logic                 oe_n,
    output logic [WORD_W-1:0]    rd_data
);

    logic [STAT_W-1:0] bank_bytes [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic clr_hit;
        assign clr_hit = clr_req && (clr_bank == BANK_W'(b));

        flash_status_bank i_bank (
            .clk          (clk),
            .rst_n        (rst_n),
            .ev_busy      (ev_busy[b]),
            .ev_done      (ev_done[b]),
            .ev_psus      (ev_psus[b]),
            .ev_esus      (ev_esus[b]),
            .ev_lock_err  (ev_lock_err[b]),
            .ev_vpp_err   (ev_vpp_err[b]),
            .ev_prog_err  (ev_prog_err[b]),
            .ev_erase_err (ev_erase_err[b]),
            .clr          (clr_hit),
            .stat_byte    (bank_bytes[b])
        );
    end

    flash_status_read #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .WORD_W    (WORD_W)
    ) i_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .rd_bank    (rd_bank),
        .bank_bytes (bank_bytes),
        .rd_data    (rd_data)
    );

endmodule

// File: tb/test_flash_bank_status.sv
module test_flash_bank_status;

    localparam int NB = 2;
    localparam int BW = 1;

    logic clk = 0;
    logic rst_n = 0;
    logic [NB-1:0] ev_busy = '0, ev_done = '0, ev_psus = '0, ev_esus = '0;
    logic [NB-1:0] ev_lock_err = '0, ev_vpp_err = '0, ev_prog_err = '0, ev_erase_err = '0;
    logic clr_req = 0;
    logic [BW-1:0] clr_bank = '0, rd_bank = '0;
    logic ce_n = 1, oe_n = 1;
    logic [15:0] rd_data;

    int total = 0, bad = 0;
    logic [7:0] exp_b [NB];

    always #10 clk = ~clk;

    flash_bank_status #(.NUM_BANKS(NB)) i_flash_bank_status (
        .clk, .rst_n, .ev_busy, .ev_done, .ev_psus, .ev_esus,
        .ev_lock_err, .ev_vpp_err, .ev_prog_err, .ev_erase_err,
        .clr_req, .clr_bank, .rd_bank, .ce_n, .oe_n, .rd_data
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kinds map: bit0 busy, bit7 done, bit2 psus, bit6 esus, bits 1,3,4,5 errors
    task automatic model(input int b, input logic [7:0] k, input bit clr);
        if (k[0]) exp_b[b] = exp_b[b] & 8'h3A;
        if (k[7]) exp_b[b][7] = 1'b1;
        if (k[2]) exp_b[b] = exp_b[b] | 8'h84;
        if (k[6]) exp_b[b] = exp_b[b] | 8'hC0;
        if (clr)  exp_b[b] = exp_b[b] & 8'hC5;
        exp_b[b] = exp_b[b] | (k & 8'h3A);
    endtask

    task automatic drive_ev(input int b, input logic [7:0] k);
        ev_busy[b] = k[0]; ev_done[b] = k[7]; ev_psus[b] = k[2]; ev_esus[b] = k[6];
        ev_lock_err[b] = k[1]; ev_vpp_err[b] = k[3];
        ev_prog_err[b] = k[4]; ev_erase_err[b] = k[5];
    endtask

    task automatic fire(input int b, input logic [7:0] k, input bit clr, input int cb);
        @(negedge clk);
        drive_ev(b, k);
        clr_req = clr; clr_bank = BW'(cb);
        @(negedge clk);
        drive_ev(b, 8'h00);
        clr_req = 0;
        model(b, k, clr && (cb == b));
    endtask

    task automatic read_chk(input string req, input int b);
        @(negedge clk);
        rd_bank = BW'(b); ce_n = 0; oe_n = 0;
        @(negedge clk);
        check(req, rd_data, {8'h00, exp_b[b]});
        ce_n = 1; oe_n = 1;
        @(negedge clk);
        check("R11 idle", rd_data, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_b[0] = 8'h80; exp_b[1] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1;
        read_chk("R1 reset bank0", 0);
        read_chk("R1 reset bank1", 1);

        // R4/R5/R7/R10: sweep all error masks on each bank
        for (int b = 0; b < NB; b++) begin
            for (int m = 0; m < 16; m++) begin
                logic [7:0] k;
                k = {2'b00, m[3], m[2], m[1], 1'b0, m[0], 1'b0};
                fire(b, k, 0, 0);
                read_chk("R4 error set", b);
                read_chk("R10 other bank", 1 - b);
                fire(b, 8'h01, 0, 0);          // busy
                fire(b, 8'h80, 0, 0);          // done
                read_chk("R4 sticky after busy/done", b);
                fire(1 - b, 8'h00, 1, 1 - b);  // clear other bank
                read_chk("R5 other bank untouched", b);
                fire(b, 8'h00, 1, b);
                read_chk("R5 cleared", b);
            end
        end

        // R2/R3 suspend and busy
        for (int b = 0; b < NB; b++) begin
            fire(b, 8'h01, 0, 0);
            read_chk("R2 busy clears ready", b);
            fire(b, 8'h04, 0, 0);
            read_chk("R3 program suspend", b);
            fire(b, 8'h01, 0, 0);
            read_chk("R2 resume clears suspend", b);
            fire(b, 8'h40, 0, 0);
            read_chk("R3 erase suspend", b);
            fire(b, 8'h10, 0, 0);
            fire(b, 8'h00, 1, b);
            read_chk("R5 clear keeps ready/suspend", b);
            fire(b, 8'h81, 0, 0);
            read_chk("R2 done beats busy", b);
            fire(b, 8'h28, 1, b);
            read_chk("R6 set beats clear", b);
            fire(b, 8'h00, 1, b);
            read_chk("R5 clear again", b);
        end

        // R8: ce first, register changes, oe falls later -> new value captured
        @(negedge clk);
        rd_bank = 0; ce_n = 0;
        @(negedge clk);
        check("R8 ce only", rd_data, 16'h0000);
        drive_ev(0, 8'h10);
        @(negedge clk);
        drive_ev(0, 8'h00); model(0, 8'h10, 0);
        oe_n = 0;
        @(negedge clk);
        check("R8 later edge ce-first", rd_data, {8'h00, exp_b[0]});
        // R9: change while held
        drive_ev(0, 8'h20);
        @(negedge clk);
        drive_ev(0, 8'h00);
        check("R9 held", rd_data, {8'h00, exp_b[0]});
        model(0, 8'h20, 0);
        @(negedge clk);
        check("R9 still held", rd_data, {8'h00, exp_b[0] & 8'hDF});
        ce_n = 1; oe_n = 1;
        @(negedge clk);
        check("R11 after release", rd_data, 16'h0000);
        // oe first, then ce
        oe_n = 0; rd_bank = 1;
        @(negedge clk);
        check("R8 oe only", rd_data, 16'h0000);
        drive_ev(1, 8'h02);
        @(negedge clk);
        drive_ev(1, 8'h00); model(1, 8'h02, 0);
        ce_n = 0;
        @(negedge clk);
        check("R8 later edge oe-first", rd_data, {8'h00, exp_b[1]});
        rd_bank = 0;
        @(negedge clk);
        check("R9 bank change ignored while held", rd_data, {8'h00, exp_b[1]});
        ce_n = 1; oe_n = 1;
        read_chk("R10 bank0 after", 0);
        read_chk("R7 bank1 after", 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule